// File: doc/BRIEF.md
# Monochrome-to-Colour Write Expander

This block sits on the host write path in front of a framebuffer write port. It takes host bytes and, when colour expansion is on, treats each byte as a one-bit-per-pixel bitmap. Every bitmap bit becomes one full pixel. A set bit selects the foreground colour and a clear bit selects the background colour. The block issues one pixel per clock, together with a write enable for that pixel and a marker on the final pixel that came from the byte.

There are two expansion flavours. The narrow flavour targets 16-colour memory: it expands all eight bits and keeps only the low four bits of each colour. The nibble flavour targets 256-colour memory: it expands only the upper four bits, so four full 8-bit pixels come out of each byte. An optional background transparency clears the write enable of every pixel whose source bit is 0, so the framebuffer keeps its old contents there. When expansion is off, each host byte leaves unchanged as a single 8-bit pixel.

The block latches the host byte, the mode and both colours when it accepts the byte. It holds its ready output low until the last pixel of that byte is on the output.

Top module: `mono_colour_expander`

## Requirements
- R1: While reset is asserted, and until the internal reset release completes, `pix_vld` is 0. Once the block is running and idle, `host_rdy` is 1.
- R2: With `cx_enable`=0, an accepted byte produces exactly one pixel equal to the byte, with `pix_we`=1 and `pix_last`=1. The value of `cx_nibble` does not matter in this case.
- R3: With `cx_enable`=1 and `cx_nibble`=0, an accepted byte produces eight pixels, starting from bit 7 and ending with bit 0. A bit of 1 gives `{4'h0, fg[3:0]}` and a bit of 0 gives `{4'h0, bg[3:0]}`.
- R4: With `cx_enable`=1 and `cx_nibble`=1, an accepted byte produces four pixels from bits 7, 6, 5 and 4, in that order. A bit of 1 gives the full `fg` and a bit of 0 gives the full `bg`. Bits 3..0 of the byte have no effect.
- R5: In either expansion mode with `cx_transp`=1, pixels from 0 bits carry `pix_we`=0 and pixels from 1 bits carry `pix_we`=1. With `cx_transp`=0, every pixel carries `pix_we`=1.
- R6: `cx_transp` has no effect when expansion is off: pass-through pixels always carry `pix_we`=1.
- R7: `pix_last` is 1 on the final pixel of each byte and 0 on every other pixel. If no new byte was accepted in the cycle of the final pixel, `pix_vld` is 0 in the next cycle.
- R8: `host_rdy` is 0 in every cycle in which a pixel of the current byte is still due after the one on the output. It is 1 in the cycle of the final pixel, so a byte accepted then starts its first pixel in the following cycle.
- R9: The mode, the transparency setting and both colours are captured when a byte is accepted. Changing them while that byte is being expanded does not alter its pixels.
- R10: The first pixel of an accepted byte appears in the cycle after acceptance. The pixels of one byte follow on consecutive cycles with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_vld | input | 1 | Host byte offered |
| host_data | input | 8 | Host byte (bitmap or pixel) |
| host_rdy | output | 1 | Block can accept a byte this cycle |
| fg_colour | input | 8 | Foreground colour for 1 bits |
| bg_colour | input | 8 | Background colour for 0 bits |
| cx_enable | input | 1 | 1: colour expansion, 0: pass-through |
| cx_nibble | input | 1 | 1: four-pixel 256-colour expansion, 0: eight-pixel 16-colour expansion |
| cx_transp | input | 1 | 1: suppress writes of background pixels |
| pix_vld | output | 1 | Pixel valid |
| pix_data | output | 8 | Pixel value |
| pix_we | output | 1 | Write enable for this pixel |
| pix_last | output | 1 | Final pixel of the current byte |

## Verification
Several rules are checked on every clock:
- a ready flag held low while pixels remain;
- an unbroken burst that follows each acceptance;
- a clean stop after the final pixel;
- write enable forced on in pass-through;
- cleared upper bits in the narrow mode;
- configuration held frozen during a burst.

The actual pixel values can only be shown by the bench's scenarios. These include the most-significant-first order, the foreground/background choice per bit, the ignored low nibble, and transparency applied to background pixels only. Two further behaviours also depend on the scenarios. One is the immunity of an in-flight byte to configuration changes. The other is back-to-back bursts, compared against the reference queue.

// File: rtl/xp_pkg.sv
package xp_pkg;

  // Latched operating mode of one accepted byte
  typedef enum logic [1:0] {
    XM_PASS   = 2'd0,  // byte written unchanged as one pixel
    XM_NARROW = 2'd1,  // eight pixels, low half of colours
    XM_NIBBLE = 2'd2   // four pixels from upper half, full colours
  } xmode_e;

  function automatic xmode_e xp_decode(input logic en, input logic nib);
    if (!en)     return XM_PASS;
    else if (nib) return XM_NIBBLE;
    else          return XM_NARROW;
  endfunction

endpackage

// File: rtl/xp_rst_sync.sv
module xp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/xp_seq.sv
module xp_seq
  import xp_pkg::*;
#(
  parameter int PIX_W = 8,
  localparam int CNT_W = $clog2(PIX_W),
  localparam int HALF  = PIX_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_vld,
  input  logic [PIX_W-1:0] host_data,
  output logic             host_rdy,
  input  logic [PIX_W-1:0] fg_in,
  input  logic [PIX_W-1:0] bg_in,
  input  logic             cx_enable,
  input  logic             cx_nibble,
  input  logic             cx_transp,
  output logic             busy_o,
  output logic             last_o,
  output logic             bit_o,
  output logic [PIX_W-1:0] word_o,
  output xmode_e           mode_o,
  output logic             transp_o,
  output logic [PIX_W-1:0] fg_o,
  output logic [PIX_W-1:0] bg_o
);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PIX_W-1:0] sh_q, sh_d;
  xmode_e           mode_q, mode_d;
  logic             transp_q;
  logic [PIX_W-1:0] fg_q, bg_q;
  logic             take, last, sh_en;

  assign last     = busy_q && (cnt_q == '0);
  assign host_rdy = rst_n && (!busy_q || last);
  assign take     = host_vld && host_rdy;
  assign sh_en    = take || busy_q;

  // Next-state logic
  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    mode_d = xp_decode(cx_enable, cx_nibble);
    if (take) begin
      busy_d = 1'b1;
      sh_d   = host_data;
      unique case (mode_d)
        XM_NARROW: cnt_d = CNT_W'(PIX_W - 1);
        XM_NIBBLE: cnt_d = CNT_W'(HALF - 1);
        default:   cnt_d = '0;
      endcase
    end else if (busy_q) begin
      if (last) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
        sh_d  = {sh_q[PIX_W-2:0], 1'b0};
      end
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  // Data path registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (sh_en) begin
      sh_q <= sh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= XM_PASS;
      transp_q <= 1'b0;
      fg_q     <= '0;
      bg_q     <= '0;
    end else if (take) begin
      mode_q   <= mode_d;
      transp_q <= cx_transp;
      fg_q     <= fg_in;
      bg_q     <= bg_in;
    end
  end

  assign busy_o   = busy_q;
  assign last_o   = last;
  assign bit_o    = sh_q[PIX_W-1];
  assign word_o   = sh_q;
  assign mode_o   = mode_q;
  assign transp_o = transp_q;
  assign fg_o     = fg_q;
  assign bg_o     = bg_q;

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !last |=> $stable(fg_q) && $stable(bg_q) && $stable(mode_q) && $stable(transp_q)) // R9
    else $error("configuration changed during a burst");

endmodule

// File: rtl/xp_colour.sv
module xp_colour
  import xp_pkg::*;
#(
  parameter int PIX_W = 8,
  localparam int HALF = PIX_W / 2
) (
  input  xmode_e           mode,
  input  logic             transp,
  input  logic             src_bit,
  input  logic [PIX_W-1:0] word,
  input  logic [PIX_W-1:0] fg,
  input  logic [PIX_W-1:0] bg,
  output logic [PIX_W-1:0] pix,
  output logic             we
);

  logic [PIX_W-1:0] pick;

  assign pick = src_bit ? fg : bg;

  always_comb begin
    unique case (mode)
      XM_NARROW: begin
        pix = {{(PIX_W-HALF){1'b0}}, pick[HALF-1:0]};
        we  = src_bit || !transp;
      end
      XM_NIBBLE: begin
        pix = pick;
        we  = src_bit || !transp;
      end
      default: begin
        pix = word;
        we  = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/mono_colour_expander.sv
module mono_colour_expander
  import xp_pkg::*;
#(
  parameter int PIX_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int HALF = PIX_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_vld,
  input  logic [PIX_W-1:0] host_data,
  output logic             host_rdy,
  input  logic [PIX_W-1:0] fg_colour,
  input  logic [PIX_W-1:0] bg_colour,
  input  logic             cx_enable,
  input  logic             cx_nibble,
  input  logic             cx_transp,
  output logic             pix_vld,
  output logic [PIX_W-1:0] pix_data,
  output logic             pix_we,
  output logic             pix_last
);

  logic             rst_n_s;
  logic             busy, last, cur_bit, transp;
  logic [PIX_W-1:0] word, fg_l, bg_l;
  xmode_e           mode;

  xp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  xp_seq #(.PIX_W(PIX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .host_vld  (host_vld),
    .host_data (host_data),
    .host_rdy  (host_rdy),
    .fg_in     (fg_colour),
    .bg_in     (bg_colour),
    .cx_enable (cx_enable),
    .cx_nibble (cx_nibble),
    .cx_transp (cx_transp),
    .busy_o    (busy),
    .last_o    (last),
    .bit_o     (cur_bit),
    .word_o    (word),
    .mode_o    (mode),
    .transp_o  (transp),
    .fg_o      (fg_l),
    .bg_o      (bg_l)
  );

  xp_colour #(.PIX_W(PIX_W)) u_col (
    .mode    (mode),
    .transp  (transp),
    .src_bit (cur_bit),
    .word    (word),
    .fg      (fg_l),
    .bg      (bg_l),
    .pix     (pix_data),
    .we      (pix_we)
  );

  assign pix_vld  = busy;
  assign pix_last = last;

  AST_RDY_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n_s)
    pix_vld && !pix_last |-> !host_rdy) // R8
    else $error("ready raised while pixels remain");

  AST_ACCEPT_THEN_PIXEL: assert property (@(posedge clk) disable iff (!rst_n_s)
    host_vld && host_rdy |=> pix_vld) // R10
    else $error("no pixel after acceptance");

  AST_BURST_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n_s)
    pix_vld && !pix_last |=> pix_vld) // R10
    else $error("gap inside a burst");

  AST_DRAIN_ENDS: assert property (@(posedge clk) disable iff (!rst_n_s)
    pix_vld && pix_last && !(host_vld && host_rdy) |=> !pix_vld) // R7
    else $error("pixel issued after final pixel");

  AST_PASS_WRITES: assert property (@(posedge clk) disable iff (!rst_n_s)
    pix_vld && (mode == XM_PASS) |-> pix_we && pix_last) // R6
    else $error("pass-through pixel not written as single pixel");

  AST_NARROW_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n_s)
    pix_vld && (mode == XM_NARROW) |-> (pix_data[PIX_W-1:HALF] == '0)) // R3
    else $error("narrow pixel has upper bits set");

endmodule

// File: tb/tb_mono_colour_expander.sv
`timescale 1ns/1ps
module tb_mono_colour_expander;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_vld;
  logic [7:0] host_data;
  logic       host_rdy;
  logic [7:0] fg_colour, bg_colour;
  logic       cx_enable, cx_nibble, cx_transp;
  logic       pix_vld, pix_we, pix_last;
  logic [7:0] pix_data;

  always #4 clk = ~clk;  // 125 MHz

  mono_colour_expander dut (
    .clk(clk), .rst_n(rst_n), .host_vld(host_vld), .host_data(host_data),
    .host_rdy(host_rdy), .fg_colour(fg_colour), .bg_colour(bg_colour),
    .cx_enable(cx_enable), .cx_nibble(cx_nibble), .cx_transp(cx_transp),
    .pix_vld(pix_vld), .pix_data(pix_data), .pix_we(pix_we), .pix_last(pix_last)
  );

  int checks = 0;
  int errors = 0;
  bit chk_on = 0;
  bit done   = 0;
  string scen_tag = "";

  logic [9:0] exp_q[$];   // {last, we, data}
  string      tag_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Behavioural reference: pixels queued at acceptance, one compared per cycle
  always @(negedge clk) begin
    if (chk_on && !done) begin
      bit ev;
      ev = (exp_q.size() > 0);
      check(pix_vld == ev, "R10", "pix_vld", pix_vld, ev);
      if (ev) begin
        logic [9:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(pix_vld && pix_data == e[7:0], t, "pix_data", pix_data, e[7:0]);
        check(pix_we == e[8], t, "pix_we", pix_we, e[8]);
        check(pix_last == e[9], "R7", "pix_last", pix_last, e[9]);
      end
      check(host_rdy == (exp_q.size() == 0), "R8", "host_rdy", host_rdy,
            exp_q.size() == 0);
      if (host_vld && host_rdy) begin
        if (!cx_enable) begin
          exp_q.push_back({1'b1, 1'b1, host_data});
          tag_q.push_back(scen_tag != "" ? scen_tag : (cx_transp ? "R6" : "R2"));
        end else begin
          int n;
          n = cx_nibble ? 4 : 8;
          for (int i = 0; i < n; i++) begin
            bit b;
            logic [7:0] c;
            string t;
            b = host_data[7-i];
            c = b ? fg_colour : bg_colour;
            if (!cx_nibble) c = {4'h0, c[3:0]};
            if (scen_tag != "") t = scen_tag;
            else if (cx_transp) t = "R5";
            else t = cx_nibble ? "R4" : "R3";
            exp_q.push_back({(i == n-1), (b || !cx_transp), c});
            tag_q.push_back(t);
          end
        end
      end
    end
  end

  // Drive at posedge + 2 ns; acceptance known at the preceding negedge
  task automatic send(input logic [7:0] b);
    bit ok;
    host_vld  = 1'b1;
    host_data = b;
    do begin
      @(negedge clk); #1;
      ok = host_rdy;
    end while (!ok);
    @(posedge clk); #2;
  endtask

  task automatic idle_drain();
    host_vld = 1'b0;
    do begin
      @(posedge clk); #2;
    end while (exp_q.size() > 0);
    @(posedge clk); #2;
  endtask

  task automatic set_mode(input bit en, input bit nib, input bit tr,
                          input logic [7:0] fg, input logic [7:0] bg);
    cx_enable = en; cx_nibble = nib; cx_transp = tr;
    fg_colour = fg; bg_colour = bg;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        done = 1;
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    host_vld = 1'b0; host_data = 8'h00;
    set_mode(1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    repeat (3) @(posedge clk);
    #2;
    check(pix_vld == 1'b0, "R1", "pix_vld in reset", pix_vld, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check(pix_vld == 1'b0, "R1", "pix_vld after reset", pix_vld, 0);
    check(host_rdy == 1'b1, "R1", "host_rdy after reset", host_rdy, 1);
    chk_on = 1;

    // R2 / R6: pass-through, transparency and nibble bit without effect
    set_mode(1'b0, 1'b0, 1'b0, 8'h11, 8'h22);
    send(8'hA5); idle_drain();
    set_mode(1'b0, 1'b1, 1'b1, 8'h11, 8'h22);
    send(8'h00); send(8'h3C); idle_drain();

    // R3: narrow expansion, upper colour bits dropped
    set_mode(1'b1, 1'b0, 1'b0, 8'hC7, 8'h5A);
    send(8'hB2); idle_drain();
    send(8'hFF); send(8'h00); idle_drain();

    // R4: nibble expansion, low nibble ignored
    set_mode(1'b1, 1'b1, 1'b0, 8'hE1, 8'h2D);
    send(8'h9F); send(8'h90); idle_drain();

    // R5: transparency in both expansion modes
    set_mode(1'b1, 1'b1, 1'b1, 8'h77, 8'h88);
    send(8'h5A); idle_drain();
    set_mode(1'b1, 1'b0, 1'b1, 8'h3E, 8'h41);
    send(8'hC3); idle_drain();

    // R8 / R10: back-to-back bytes across mode changes
    set_mode(1'b1, 1'b1, 1'b0, 8'hF0, 8'h0F);
    send(8'hA0); send(8'h50);
    set_mode(1'b0, 1'b0, 1'b0, 8'hF0, 8'h0F);
    send(8'h81);
    set_mode(1'b1, 1'b0, 1'b1, 8'h96, 8'h69);
    send(8'h6D); idle_drain();

    // R9: configuration changed while a byte is expanding
    scen_tag = "R9";
    set_mode(1'b1, 1'b0, 1'b0, 8'h0B, 8'h04);
    send(8'hD4);
    set_mode(1'b0, 1'b1, 1'b1, 8'hFF, 8'hEE);
    host_vld = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    set_mode(1'b1, 1'b1, 1'b0, 8'h12, 8'h34);
    idle_drain();
    scen_tag = "";

    repeat (3) @(posedge clk);
    #2;
    check(exp_q.size() == 0 && pix_vld == 1'b0, "R7", "idle at end", pix_vld, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule